// File: doc/BRIEF.md
# Normal-Basis Field Inverter Sequencer

This block computes the multiplicative inverse of a nonzero element of GF(2^163) in normal-basis form. It raises the operand A to the power 2^163 - 2 through a fixed addition chain. The chain builds A^(2^s - 1) for s = 1, 2, 4, 5, 10, 20, 40, 80, 81 and 162. It then squares the last value once. In a normal basis, raising to 2^j is a left rotation of the word by j positions. So each run of squarings becomes a single rotation by a variable amount.

Products are not computed here. Each of the nine products is handed to an external field multiplier through a request/response handshake. The block latches the answer and moves to the next chain step. A zero operand has no inverse and is rejected with a one-cycle error flag. The block sits beside a shared field multiplier inside a larger coordinate-conversion engine.

Top module: `nb_inv_seq`

## Requirements
- R1: While reset is low and in the cycle after it, `done`, `error`, `busy` and `mul_req` are 0 and `result` is all zeros.
- R2: A `start` sampled while idle with a nonzero `operand` issues exactly nine multiply requests before `done`.
- R3: `mul_req` is a one-cycle pulse. The next request is issued only after a `mul_done` pulse answers the previous one.
- R4: A rotation means a left rotation: bit i moves to bit (i+j) mod 163. The operands of request n follow the chain:
  - request 1 sends the rotation of A by 1 and A itself;
  - requests 3 and 8 send A on `mul_b`;
  - request 9 sends, on `mul_a`, the product of request 8 rotated by 81, and that product itself on `mul_b`.
- R5: `result` equals the ninth product rotated left by one position.
- R6: `done` is high for exactly one cycle. `result` changes only in the cycle `done` is high and is held until the next inversion completes.
- R7: With a multiplier that answers L cycles after seeing a request, `done` rises 9*(1+L)+1 clock edges after the edge that samples `start`.
- R8: A `start` with an all-zero `operand` raises `error` for exactly one cycle on the next edge. It issues no request, raises no `done` and leaves `result` unchanged.
- R9: A `start` that arrives while `busy` is high is ignored. This includes the cycle in which `mul_done` answers. The running inversion completes on its original operand.
- R10: A `mul_done` pulse while no request is outstanding has no effect on `result`, `done` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an inversion of `operand` (taken only while idle) |
| operand | input | 163 | Element to invert, normal basis |
| result | output | 163 | Inverse of the last accepted operand |
| done | output | 1 | One-cycle pulse: `result` is valid |
| error | output | 1 | One-cycle pulse: zero operand rejected |
| busy | output | 1 | Chain in progress |
| mul_req | output | 1 | One-cycle multiply request |
| mul_a | output | 163 | First multiplier operand (rotated intermediate) |
| mul_b | output | 163 | Second multiplier operand (A or saved intermediate) |
| mul_done | input | 1 | Multiplier answer strobe |
| mul_prod | input | 163 | Multiplier product, sampled with `mul_done` |

## Verification
A new request to start can land in the same cycle that the multiplier answers. Here the chain must advance, and the new operand must be dropped.

The bench waits for the rising edge of `mul_done` in the middle of a run and raises `start` with a different operand across that edge. It then judges the outcome in three ways:
- the result must still match the first operand;
- there must be exactly nine requests;
- `done` must arrive at the cycle count that the multiplier latency predicts.

A second overlap applies a spurious `mul_done` while idle. The bench checks that `result`, `done` and `busy` do not move.

// File: rtl/nb_inv_pkg.sv
// Package: shared state encoding and chain constants for the normal-basis
// inverter. Assumes the chain is the fixed one for a 163-bit field.
package nb_inv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } inv_state_t;

    localparam int CHAIN_STEPS = 9;
endpackage

// File: rtl/nb_inv_chain_rom.sv
// Chain step decoder: for each step index returns the rotation applied to
// the running value and whether the second operand is the original A.
// Assumes ROT_W can hold 81 and step indices 0..8.
module nb_inv_chain_rom #(
    parameter int ROT_W  = 8,
    parameter int STEP_W = 4
) (
    input  logic [STEP_W-1:0] step,
    output logic [ROT_W-1:0]  rot_amt,
    output logic              use_orig
);
    // Decode step index into rotation amount and operand source.
    always_comb begin
        rot_amt  = ROT_W'(1);
        use_orig = 1'b0;
        case (step)
            STEP_W'(0): rot_amt = ROT_W'(1);                    // s: 1 -> 2
            STEP_W'(1): rot_amt = ROT_W'(2);                    // s: 2 -> 4
            STEP_W'(2): begin rot_amt = ROT_W'(1); use_orig = 1'b1; end // 4 -> 5
            STEP_W'(3): rot_amt = ROT_W'(5);                    // 5 -> 10
            STEP_W'(4): rot_amt = ROT_W'(10);                   // 10 -> 20
            STEP_W'(5): rot_amt = ROT_W'(20);                   // 20 -> 40
            STEP_W'(6): rot_amt = ROT_W'(40);                   // 40 -> 80
            STEP_W'(7): begin rot_amt = ROT_W'(1); use_orig = 1'b1; end // 80 -> 81
            STEP_W'(8): rot_amt = ROT_W'(81);                   // 81 -> 162
            default:    rot_amt = ROT_W'(1);
        endcase
    end
endmodule

// File: rtl/nb_rotl.sv
// Variable left rotation of an M-bit word: bit i moves to (i+amt) mod M.
// This is repeated squaring in a normal basis. Assumes amt < M.
module nb_rotl #(
    parameter int M     = 163,
    parameter int ROT_W = 8
) (
    input  logic [M-1:0]     din,
    input  logic [ROT_W-1:0] amt,
    output logic [M-1:0]     dout
);
    logic [2*M-1:0] dbl;

    // Shift a doubled copy so the upper half holds the rotated word.
    always_comb begin
        dbl  = {din, din} << amt;
        dout = dbl[2*M-1:M];
    end
endmodule

// File: rtl/nb_inv_seq.sv
// Normal-basis inverter sequencer: walks a nine-product addition chain for
// A^(2^163-2), rotating the running value and requesting each product from
// an external multiplier. Assumes the multiplier answers no earlier than
// the cycle after a request and that mul_prod is valid with mul_done.
module nb_inv_seq
    import nb_inv_pkg::*;
#(
    parameter int M      = 163,
    parameter int ROT_W  = $clog2(M),
    parameter int STEP_W = $clog2(CHAIN_STEPS + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic [M-1:0] result,
    output logic         done,
    output logic         error,
    output logic         busy,
    output logic         mul_req,
    output logic [M-1:0] mul_a,
    output logic [M-1:0] mul_b,
    input  logic         mul_done,
    input  logic [M-1:0] mul_prod
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CHAIN_STEPS - 1);

    inv_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [M-1:0]      orig_q;
    logic [M-1:0]      run_q;
    logic [M-1:0]      result_q;
    logic              done_q;
    logic              err_q;
    logic [ROT_W-1:0]  rom_rot;
    logic              rom_use_orig;
    logic [ROT_W-1:0]  rot_sel;
    logic [M-1:0]      rot_out;

    nb_inv_chain_rom #(.ROT_W(ROT_W), .STEP_W(STEP_W)) u_rom (
        .step     (step_q),
        .rot_amt  (rom_rot),
        .use_orig (rom_use_orig)
    );

    // Final step squares once; otherwise the chain table picks the amount.
    always_comb rot_sel = (state_q == ST_FIN) ? ROT_W'(1) : rom_rot;

    nb_rotl #(.M(M), .ROT_W(ROT_W)) u_rot (
        .din  (run_q),
        .amt  (rot_sel),
        .dout (rot_out)
    );

    // Sequencer: accept, issue, wait for product, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            orig_q   <= '0;
            run_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (operand == '0) begin
                            err_q <= 1'b1;
                        end else begin
                            orig_q  <= operand;
                            run_q   <= operand;
                            step_q  <= '0;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mul_done) begin
                        run_q <= mul_prod;
                        if (step_q == LAST_STEP) begin
                            state_q <= ST_FIN;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_FIN: begin
                    result_q <= rot_out;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the outward-facing ports from state.
    always_comb begin
        mul_req = (state_q == ST_ISSUE);
        mul_a   = rot_out;
        mul_b   = rom_use_orig ? orig_q : run_q;
        busy    = (state_q != ST_IDLE);
        result  = result_q;
        done    = done_q;
        error   = err_q;
    end

    // R3: a request never lasts two cycles.
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mul_req |=> !mul_req);

    // R2: step index never passes the end of the chain.
    a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_q <= LAST_STEP));

    // R6: completion strobe is a single cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: result only moves together with done.
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R8: zero operand flags an error and does not start the chain.
    a_r8_zero_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && operand == '0) |=> (error && !busy && !done));

    // R9: the latched operand is frozen while a run is in progress.
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(orig_q));

    // R10: a stray answer while idle starts nothing.
    a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && mul_done) |=> (!busy && !done));
endmodule

// File: tb/nb_inv_seq_tb.sv
// Bench for nb_inv_seq. The stand-in multiplier returns the XOR of its
// operands. Under that map a product is a sum and a squaring a rotation,
// so the whole chain yields the XOR of rotations 1..162 of A. That equals
// A xor (parity(A) replicated), which is computed here without the RTL.
`timescale 1ns/1ps
module nb_inv_seq_tb;
    localparam int M = 163;
    localparam int NV = 6;
    localparam logic [M-1:0] VEC_OP [NV] = '{
        163'h1,
        {M{1'b1}},
        163'h5_5555_5555_5555_5555_5555_5555_5555_5555_5555_5555,
        163'h3_1415_9265_3589_7932_3846_2643_3832_7950_2884_1971,
        163'h80_0000_0001,
        (163'h1 << 162)
    };
    localparam int VEC_LAT [NV] = '{1, 1, 2, 3, 1, 4};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic [M-1:0] result;
    logic         done, error, busy, mul_req;
    logic [M-1:0] mul_a, mul_b;
    logic         mul_done = 1'b0;
    logic [M-1:0] mul_prod = '0;

    int n_checks = 0;
    int n_fail = 0;
    int finished = 0;

    nb_inv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .result(result), .done(done), .error(error), .busy(busy),
        .mul_req(mul_req), .mul_a(mul_a), .mul_b(mul_b),
        .mul_done(mul_done), .mul_prod(mul_prod)
    );

    always #4 clk = ~clk;

    // Stand-in multiplier: answers lat_cfg negedges after seeing a request.
    int           lat_cfg = 1;
    int           cnt = 0;
    int           req_cnt = 0;
    logic         spur = 1'b0;
    logic [M-1:0] hold = '0;
    logic [M-1:0] log_a [64];
    logic [M-1:0] log_b [64];
    always @(negedge clk) begin
        if (spur) begin
            mul_done = 1'b1;
            mul_prod = {M{1'b1}};
        end else if (cnt > 0) begin
            cnt = cnt - 1;
            mul_done = (cnt == 0);
            if (cnt == 0) mul_prod = hold;
        end else begin
            mul_done = 1'b0;
        end
        if (mul_req) begin
            hold = mul_a ^ mul_b;
            cnt = lat_cfg;
            log_a[req_cnt % 64] = mul_a;
            log_b[req_cnt % 64] = mul_b;
            req_cnt = req_cnt + 1;
        end
    end

    function automatic logic [M-1:0] rotl(input logic [M-1:0] x, input int j);
        logic [M-1:0] y;
        for (int i = 0; i < M; i++) y[(i + j) % M] = x[i];
        return y;
    endfunction

    function automatic logic [M-1:0] model_inv(input logic [M-1:0] a);
        return a ^ {M{^a}};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [M-1:0] act, input logic [M-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Start one inversion and count edges until done (R7 timing).
    task automatic run_inv(input logic [M-1:0] op, input int lat,
                           output int cyc, output int base);
        lat_cfg = lat;
        @(negedge clk);
        base = req_cnt;
        operand = op;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        int cyc;
        int base;
        logic [M-1:0] held;
        logic [M-1:0] p8;
        logic [M-1:0] p9;
        logic         saw_done;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 0 && error == 0 && busy == 0 && mul_req == 0, "R1 flags",
              {error, done, busy, mul_req}, '0);
        check(result == '0, "R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && busy == 0 && mul_req == 0 && result == '0,
              "R1 after release", result, '0);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            run_inv(VEC_OP[v], VEC_LAT[v], cyc, base);
            check(cyc == 9 * (1 + VEC_LAT[v]) + 1, "R7 latency",
                  M'(cyc), M'(9 * (1 + VEC_LAT[v]) + 1));
            check(req_cnt - base == 9, "R2 request count",
                  M'(req_cnt - base), M'(9));
            check(log_a[base % 64] == rotl(VEC_OP[v], 1) &&
                  log_b[base % 64] == VEC_OP[v], "R4 first request",
                  log_a[base % 64], rotl(VEC_OP[v], 1));
            check(log_b[(base + 2) % 64] == VEC_OP[v] &&
                  log_b[(base + 7) % 64] == VEC_OP[v], "R4 orig operand",
                  log_b[(base + 7) % 64], VEC_OP[v]);
            p8 = log_a[(base + 7) % 64] ^ log_b[(base + 7) % 64];
            check(log_a[(base + 8) % 64] == rotl(p8, 81) &&
                  log_b[(base + 8) % 64] == p8, "R4 last request",
                  log_a[(base + 8) % 64], rotl(p8, 81));
            p9 = log_a[(base + 8) % 64] ^ log_b[(base + 8) % 64];
            check(result == rotl(p9, 1), "R5 final square", result, rotl(p9, 1));
            check(result == model_inv(VEC_OP[v]), "R5 chain value",
                  result, model_inv(VEC_OP[v]));
            @(negedge clk);
            check(done == 0 && busy == 0, "R6 done one cycle",
                  M'({done, busy}), '0);
            check(result == model_inv(VEC_OP[v]), "R6 result held",
                  result, model_inv(VEC_OP[v]));
        end

        // R8: zero operand rejected.
        held = result;
        base = req_cnt;
        @(negedge clk);
        operand = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(error == 1 && busy == 0, "R8 error raised", M'({error, busy}), M'(2));
        @(negedge clk);
        check(error == 0, "R8 error one cycle", M'(error), '0);
        saw_done = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) saw_done = 1'b1;
        end
        check(!saw_done && req_cnt == base && result == held, "R8 no run",
              result, held);

        // R10: stray multiplier answer while idle.
        @(posedge clk);
        #1 spur = 1'b1;
        @(posedge clk);
        #1 spur = 1'b0;
        saw_done = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done || busy) saw_done = 1'b1;
        end
        check(!saw_done && result == held, "R10 stray ack ignored", result, held);

        // R9: start with another operand in the cycle the multiplier answers.
        lat_cfg = 2;
        @(negedge clk);
        base = req_cnt;
        operand = VEC_OP[3];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(posedge mul_done);
        operand = VEC_OP[2];
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        check(result == model_inv(VEC_OP[3]), "R9 busy start ignored",
              result, model_inv(VEC_OP[3]));
        check(req_cnt - base == 9, "R9 request count", M'(req_cnt - base), M'(9));

        if (finished == 0) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (finished == 0) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule